// File: doc/BRIEF.md
# I2C Slave Receiver with 7-bit and 10-bit Addressing

This block is the receive side of an I2C slave. It runs from a system clock that is much faster than SCL and oversamples both bus lines. It finds START, repeated START and STOP on the bus and shifts in bytes MSB first. It matches the first byte, or the first two bytes, against an address register that a host writes. A gate then decides for every byte it owns whether the byte goes to the receive buffer and gets an ACK. The gate looks at two flags, buffer-full and overflow.

In 10-bit mode the address comes in two passes. The host loads the address register with the high-byte pattern `11110 A9 A8 0`. When that byte matches, the block sets an update-address flag and holds SCL low after the acknowledge clock. The host then writes the low address byte, which releases the bus, and the slave compares the second byte against all eight bits. After that second match the block stretches SCL again so that the host can restore the high pattern. A repeated START with the high byte and the read bit set is then accepted for the rest of the transaction. Slave-transmit shifting, master operation and general call are not part of the block.

Top module: `i2cs_rx_engine`

## Requirements
- R1: After reset, buffer-full, overflow, interrupt and update-address flags are 0, and the block drives neither SCL nor SDA low.
- R2: In 7-bit mode (`mode_ten`=0), the first byte after a START is sampled on SCL rising edges, MSB first. Its bits 7:1 are compared with address register bits 7:1, and bit 0 is R/W with 0 meaning write. On a match with both flags clear, SDA is held low during the ninth clock, the byte is copied to `buf_q` and buffer-full is set.
- R3: A first byte that does not match gets no ACK and sets no flag. Later bytes of that transaction are neither acknowledged nor stored.
- R4: After an accepted write address, each data byte that arrives with buffer-full and overflow both clear is copied to the buffer and acknowledged, and buffer-full is set.
- R5: A byte that arrives while buffer-full is set is not copied and gets no ACK. It sets overflow and still sets the interrupt flag.
- R6: While overflow is set, a byte that arrives with buffer-full clear is not copied and gets no ACK. Overflow stays set until an `ovf_clr` pulse.
- R7: Every byte that passes through the gate sets the interrupt flag on the falling edge of the ninth SCL pulse. A `buf_rd` pulse clears buffer-full, and an `irq_clr` pulse clears the interrupt flag.
- R8: In 10-bit mode, a first byte equal to `11110 A9 A8` with R/W=0 that matches and is accepted sets update-address and holds SCL low after the ninth clock. A host write to the address register clears the flag and releases SCL.
- R9: In 10-bit mode the second address byte is compared on all eight bits. A match sets update-address and stretches SCL again. A mismatch gets no ACK and does not stretch.
- R10: After a full 10-bit match, a repeated START followed by the high byte with R/W=1 is acknowledged and copied, and sets the interrupt flag but not update-address. Without a full match earlier in the transaction, the same byte gets no ACK.
- R11: A STOP (SDA rising while SCL is high) returns the block to idle. Bytes clocked after a STOP without a new START get no ACK and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| mode_ten | input | 1 | 1 selects 10-bit addressing |
| addr_we | input | 1 | Host write strobe for the address register |
| addr_wdata | input | 8 | Address register write data |
| buf_rd | input | 1 | Host read strobe for the buffer, clears buffer-full |
| buf_q | output | 8 | Receive buffer contents |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| buf_full | output | 1 | Buffer-full flag |
| ovf_flag | output | 1 | Overflow flag |
| irq_flag | output | 1 | Interrupt flag |
| upd_addr | output | 1 | Update-address flag (10-bit mode) |

## Verification
The bench builds the block with the default two synchroniser stages and an 8-bit byte width. At a quarter SCL period of ten system clocks, every flag has settled well before the bench samples it. The bench's bus model ANDs its own drive with the block's pull-downs, so a master bit waits while SCL is stretched. With this model the two-pass 10-bit handshake and the repeated START read can be run end to end. The same setup reaches the buffer-full and overflow gate cases with random data.

// File: rtl/i2cs_pkg.sv
// Shared types and constants for the I2C slave receiver.
// Assumes 8-bit bus bytes; the 10-bit address tag is fixed by the bus protocol.
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam logic [4:0] TEN_TAG = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_ADR1,   // first byte after (repeated) START
        ST_ADR2,   // second byte of a 10-bit address
        ST_DATA,   // receiving data bytes
        ST_SKIP    // not addressed (or transmit): ignore until START/STOP
    } eng_st_t;
endpackage

// File: rtl/i2cs_line_sync.sv
// Synchroniser for one open-drain bus line, with edge pulses.
// Assumes STAGES >= 2; the reset value is the idle (high) line level.
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              last;

    // Shift the raw line through the flops and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
            last <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], line_i};
            last <= pipe[STAGES-1];
        end
    end

    assign line_s = pipe[STAGES-1];
    assign rise   = line_s & ~last;
    assign fall   = ~line_s & last;
endmodule

// File: rtl/i2cs_bit_shifter.sv
// Bit counter and receive shift register.
// Samples SDA on SCL rising edges. byte_done pulses on the falling edge after
// the eighth bit, and ack_done on the falling edge of the ninth (acknowledge) clock.
// Assumes scl_rise/scl_fall are single-cycle pulses from synchronised lines.
module i2cs_bit_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    output logic [BYTE_W-1:0] shreg,
    output logic              byte_done,
    output logic              ack_done
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [CNT_W-1:0] cnt;
    logic             in_ack;
    logic             ack_hi;

    assign byte_done = scl_fall & (cnt == FULL) & ~in_ack;
    assign ack_done  = scl_fall & ack_hi;

    // Count and shift data bits, then track the acknowledge clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt    <= '0;
            in_ack <= 1'b0;
            ack_hi <= 1'b0;
            if (!rst_n) shreg <= '0;
        end else if (scl_rise && !in_ack && cnt != FULL) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
        end else if (byte_done) begin
            in_ack <= 1'b1;
        end else if (scl_rise && in_ack) begin
            ack_hi <= 1'b1;
        end else if (ack_done) begin
            cnt    <= '0;
            in_ack <= 1'b0;
            ack_hi <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cs_rx_gate.sv
// Gate for a received byte. An owned byte is taken (copied and ACKed) only
// when buffer-full and overflow are both clear. It raises overflow when it
// arrives while buffer-full is set. Purely combinational.
module i2cs_rx_gate (
    input  logic hit,
    input  logic bf,
    input  logic ovf,
    output logic take,
    output logic set_ovf
);
    assign take    = hit & ~bf & ~ovf;
    assign set_ovf = hit & bf;
endmodule

// File: rtl/i2cs_rx_engine.sv
// I2C slave receive engine with 7-bit or 10-bit addressing.
// Detects START/STOP from synchronised lines, matches addresses against a
// host-written register, and gates bytes into a one-entry buffer.
// In 10-bit mode it stretches SCL after each address byte until the host
// rewrites the address register. Assumes clk is well above SCL (4x minimum per half period).
module i2cs_rx_engine
    import i2cs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] RST_ADDR    = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       mode_ten,
    input  logic       addr_we,
    input  logic [7:0] addr_wdata,
    input  logic       buf_rd,
    output logic [7:0] buf_q,
    input  logic       irq_clr,
    input  logic       ovf_clr,
    output logic       buf_full,
    output logic       ovf_flag,
    output logic       irq_flag,
    output logic       upd_addr
);
    logic scl_s, scl_rise, scl_fall;
    logic sda_s, sda_rise, sda_fall;
    logic start_c, stop_c;
    logic [BYTE_W-1:0] sh;
    logic byte_done, ack_done;
    logic hit, take, set_ovf, upd_n, full_n;
    logic hi_ok;

    eng_st_t    st, nxt;
    logic [7:0] addr_reg;
    logic       tenfull;
    logic       pend_irq, pend_upd;
    logic       stretch;
    logic       sda_drv;
    logic       byte_ev;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .line_s(scl_s), .rise(scl_rise), .fall(scl_fall));

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .line_s(sda_s), .rise(sda_rise), .fall(sda_fall));

    assign start_c = scl_s & sda_fall;
    assign stop_c  = scl_s & sda_rise;

    i2cs_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(start_c | stop_c),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .shreg(sh), .byte_done(byte_done), .ack_done(ack_done));

    i2cs_rx_gate u_gate (
        .hit(hit), .bf(buf_full), .ovf(ovf_flag),
        .take(take), .set_ovf(set_ovf));

    assign byte_ev = byte_done & (st != ST_IDLE) & ~start_c & ~stop_c;
    assign hi_ok   = (sh[7:3] == TEN_TAG) && (sh[7:1] == addr_reg[7:1]);

    // Decide address ownership, the next state and the 10-bit pass flags for the byte just shifted in.
    always_comb begin
        hit    = 1'b0;
        upd_n  = 1'b0;
        full_n = 1'b0;
        nxt    = st;
        case (st)
            ST_ADR1: begin
                if (!mode_ten) begin
                    hit = (sh[7:1] == addr_reg[7:1]);
                    nxt = (take && !sh[0]) ? ST_DATA : ST_SKIP;
                end else if (!sh[0]) begin
                    hit   = hi_ok;
                    upd_n = take;
                    nxt   = take ? ST_ADR2 : ST_SKIP;
                end else begin
                    hit = hi_ok & tenfull;
                    nxt = ST_SKIP;
                end
            end
            ST_ADR2: begin
                hit    = (sh == addr_reg);
                upd_n  = take;
                full_n = take;
                nxt    = take ? ST_DATA : ST_SKIP;
            end
            ST_DATA: begin
                hit = 1'b1;
            end
            default: ;
        endcase
    end

    // Engine state, ACK drive and pending flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            tenfull  <= 1'b0;
            sda_drv  <= 1'b0;
            pend_irq <= 1'b0;
            pend_upd <= 1'b0;
        end else if (stop_c) begin
            st       <= ST_IDLE;
            tenfull  <= 1'b0;
            sda_drv  <= 1'b0;
            pend_irq <= 1'b0;
            pend_upd <= 1'b0;
        end else if (start_c) begin
            st       <= ST_ADR1;
            sda_drv  <= 1'b0;
            pend_irq <= 1'b0;
            pend_upd <= 1'b0;
        end else if (byte_ev) begin
            st       <= nxt;
            sda_drv  <= take;
            pend_irq <= hit;
            pend_upd <= upd_n;
            if (full_n) tenfull <= 1'b1;
        end else if (ack_done) begin
            sda_drv  <= 1'b0;
            pend_irq <= 1'b0;
            pend_upd <= 1'b0;
        end
    end

    // Buffer copy and buffer-full / overflow flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (byte_ev && take) buf_q <= sh;
            buf_full <= (buf_full & ~buf_rd) | (byte_ev & take);
            ovf_flag <= (ovf_flag & ~ovf_clr) | (byte_ev & set_ovf);
        end
    end

    // Interrupt, update-address and SCL stretch, set on the ninth falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            upd_addr <= 1'b0;
            stretch  <= 1'b0;
        end else begin
            irq_flag <= (irq_flag & ~irq_clr) | (ack_done & pend_irq & ~stop_c & ~start_c);
            if (addr_we) begin
                upd_addr <= 1'b0;
                stretch  <= 1'b0;
            end else if (ack_done && pend_upd && !stop_c && !start_c) begin
                upd_addr <= 1'b1;
                stretch  <= 1'b1;
            end else if (stop_c) begin
                stretch  <= 1'b0;
            end
        end
    end

    // Host write of the address register.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_reg <= RST_ADDR;
        else if (addr_we) addr_reg <= addr_wdata;
    end

    assign scl_oe = stretch;
    assign sda_oe = sda_drv;
endmodule

// File: rtl/i2cs_rx_checks.sv
// Assertion checker for i2cs_rx_engine, attached with bind.
// Assumes it sees the engine's ports plus its synchronised SCL level.
module i2cs_rx_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       addr_we,
    input logic       buf_rd,
    input logic [7:0] buf_q,
    input logic       buf_full,
    input logic       ovf_flag,
    input logic       upd_addr
);
    // R8: SCL is only stretched while the host owes an address update.
    a_r8_stretch_needs_upd: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> upd_addr);

    // R8: an address write releases a stretched SCL.
    a_r8_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && scl_oe) |=> !scl_oe);

    // R5: overflow only rises when buffer-full was set.
    a_r5_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(buf_full));

    // R5: a full buffer is never overwritten.
    a_r5_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !buf_rd) |=> $stable(buf_q));

    // R7: reading a full buffer clears buffer-full.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && buf_full) |=> !buf_full);

    // R6: no ACK while overflow is pending.
    a_r6_no_ack_in_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !ovf_flag);

    // R2: the ACK is only put on SDA while SCL is low.
    a_r2_ack_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
endmodule

bind i2cs_rx_engine i2cs_rx_checks u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .addr_we(addr_we), .buf_rd(buf_rd), .buf_q(buf_q), .buf_full(buf_full),
    .ovf_flag(ovf_flag), .upd_addr(upd_addr));

// File: tb/sim_i2cs_rx_engine.sv
// Bench for i2cs_rx_engine. It holds a bus master model with wired-AND lines
// and a host model, and checks the block against flag predictions computed in the bench.
module sim_i2cs_rx_engine;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe;
    logic mode_ten = 1'b0;
    logic addr_we = 1'b0;
    logic [7:0] addr_wdata = 8'h00;
    logic buf_rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
    logic [7:0] buf_q;
    logic buf_full, ovf_flag, irq_flag, upd_addr;
    logic scl_w, sda_w;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    assign scl_w = scl_m & ~scl_oe;
    assign sda_w = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cs_rx_engine u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .mode_ten(mode_ten),
        .addr_we(addr_we), .addr_wdata(addr_wdata), .buf_rd(buf_rd),
        .buf_q(buf_q), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
        .buf_full(buf_full), .ovf_flag(ovf_flag), .irq_flag(irq_flag),
        .upd_addr(upd_addr));

    // Bench model of the byte gate: {take, overflow set}.
    function automatic logic [1:0] gate_exp(input logic bf, input logic ov, input logic owned);
        return {owned & ~bf & ~ov, owned & bf};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic scl_high();
        scl_m = 1'b1;
        do @(posedge clk); while (!scl_w);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wait_clk(Q);
        scl_high(); wait_clk(2*Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wait_clk(Q);
        scl_high(); wait_clk(Q);
        b = sda_w; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = ~a;
        @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_high(); wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_high(); wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic host_addr(input logic [7:0] v);
        @(negedge clk); addr_we = 1'b1; addr_wdata = v;
        @(negedge clk); addr_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_read(output logic [7:0] v);
        @(negedge clk); v = buf_q; buf_rd = 1'b1;
        @(negedge clk); buf_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_clr_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_clr_ovf();
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait_clk(150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rd, d1, d2;
        logic [1:0] g;
        void'($urandom(32'd4242));

        wait_clk(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 flags", {buf_full, ovf_flag, irq_flag, upd_addr}, 4'b0000);
        check("R1 drives", {scl_oe, sda_oe}, 2'b00);

        // R2 7-bit address 0x3A, write
        host_addr({7'h3A, 1'b0});
        bus_start();
        send_byte({7'h3A, 1'b0}, ack);
        check("R2 ack", ack, 1'b1);
        check("R2 buffer", buf_q, 8'h74);
        check("R2 full", buf_full, 1'b1);
        check("R7 irq on ninth fall", irq_flag, 1'b1);
        host_read(rd);
        check("R7 read clears full", buf_full, 1'b0);
        host_clr_irq();
        check("R7 irq cleared", irq_flag, 1'b0);

        // R4 random data bytes, read each one
        for (int k = 0; k < 6; k++) begin
            d1 = 8'($urandom);
            g = gate_exp(1'b0, 1'b0, 1'b1);
            send_byte(d1, ack);
            check("R4 ack", ack, g[1]);
            check("R4 data", buf_q, d1);
            check("R7 irq data", irq_flag, 1'b1);
            host_read(rd);
            host_clr_irq();
        end

        // R5 byte while buffer full
        d1 = 8'($urandom);
        d2 = ~d1;
        send_byte(d1, ack);
        check("R4 ack before ovf", ack, 1'b1);
        host_clr_irq();
        g = gate_exp(1'b1, 1'b0, 1'b1);
        send_byte(d2, ack);
        check("R5 nack", ack, g[1]);
        check("R5 ovf set", ovf_flag, g[0]);
        check("R5 buffer kept", buf_q, d1);
        check("R5 irq still set", irq_flag, 1'b1);
        host_read(rd);
        host_clr_irq();
        // R6 overflow pending, buffer empty
        g = gate_exp(1'b0, 1'b1, 1'b1);
        send_byte(d2, ack);
        check("R6 nack", ack, g[1]);
        check("R6 not copied", buf_full, 1'b0);
        check("R6 ovf held", ovf_flag, 1'b1);
        check("R6 irq", irq_flag, 1'b1);
        host_clr_ovf();
        host_clr_irq();
        send_byte(d2, ack);
        check("R4 ack after clear", ack, 1'b1);
        check("R4 data after clear", buf_q, d2);
        host_read(rd);
        host_clr_irq();
        bus_stop();

        // R11 bytes after STOP without START
        scl_m = 1'b0; wait_clk(Q);
        send_byte(8'h74, ack);
        check("R11 nack after stop", ack, 1'b0);
        check("R11 no irq", irq_flag, 1'b0);
        bus_stop();

        // R3 non-matching address
        bus_start();
        send_byte({7'h22, 1'b0}, ack);
        check("R3 nack", ack, 1'b0);
        check("R3 no irq", irq_flag, 1'b0);
        send_byte(8'h5A, ack);
        check("R3 data nack", ack, 1'b0);
        check("R3 no full", buf_full, 1'b0);
        bus_stop();

        // R8 / R9 / R10 10-bit address 0x2C5: high 0xF4, low 0xC5
        mode_ten = 1'b1;
        host_addr(8'hF4);
        bus_start();
        send_byte(8'hF4, ack);
        check("R8 ack high", ack, 1'b1);
        check("R8 upd set", upd_addr, 1'b1);
        wait_clk(50);
        @(negedge clk);
        check("R8 scl held", {scl_oe, scl_w}, 2'b10);
        host_read(rd);
        check("R8 high in buffer", rd, 8'hF4);
        host_clr_irq();
        host_addr(8'hC5);
        check("R8 write clears upd", {upd_addr, scl_oe}, 2'b00);
        send_byte(8'hC5, ack);
        check("R9 ack low", ack, 1'b1);
        check("R9 upd and stretch", {upd_addr, scl_oe}, 2'b11);
        host_read(rd);
        host_clr_irq();
        host_addr(8'hF4);
        d1 = 8'($urandom);
        send_byte(d1, ack);
        check("R4 10-bit data", {ack, buf_q}, {1'b1, d1});
        host_read(rd);
        host_clr_irq();
        bus_start();
        send_byte(8'hF5, ack);
        check("R10 read ack", ack, 1'b1);
        check("R10 buffer", buf_q, 8'hF5);
        check("R10 irq no upd", {irq_flag, upd_addr, scl_oe}, 3'b100);
        host_read(rd);
        host_clr_irq();
        bus_stop();

        // R9 wrong low byte
        bus_start();
        send_byte(8'hF4, ack);
        check("R8 ack high again", ack, 1'b1);
        host_read(rd);
        host_clr_irq();
        host_addr(8'hC5);
        send_byte(8'hC6, ack);
        check("R9 wrong low nack", ack, 1'b0);
        check("R9 no upd", {upd_addr, scl_oe, irq_flag}, 3'b000);
        host_addr(8'hF4);
        bus_stop();

        // R10 read without full match in this transaction
        bus_start();
        send_byte(8'hF5, ack);
        check("R10 read nack", ack, 1'b0);
        check("R10 no irq", irq_flag, 1'b0);
        bus_stop();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule